// File: doc/BRIEF.md
# Character Cell Scan Sequencer

This block walks a position counter over an 8-row by 8-column character cell for a vector-display readout. Its job is to time a character pattern generator: it raises a load pulse so the generator's current row of dots enters the dot shifter, a line pulse so the generator steps to its next row, and a clear pulse so the generator's row counter starts a new character. It also reports whether the current position lies in the cell's blanked border.

Between characters the sequencer parks. After the scan passes the cell's origin it drops its running flag and stops one column further on. It stays there until a restart timer pulses while the readout is enabled. The counter moves only on cycles where the running flag, the readout enable and the increment input from the dot-brightening logic are all high. Holding the increment input low stretches a position for as many cycles as needed, and no extra strobe fires while it is held.

Top module: `char_scan_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the position is row 0, column 1, `gen_on` is low, `blank` is high and all three strobes are low.
- R2: The position changes on a clock edge only if `gen_on`, `readout_en` and `inc_ok` were all high before that edge. Otherwise the position is held and no strobe is raised.
- R3: Each step moves the column up by one. Column 7 steps to column 0 of the next row, and row 7 column 7 steps to row 0 column 0.
- R4: A step taken from row 0 column 0 clears `gen_on` on the same edge. The sequencer therefore parks at row 0 column 1 and stays there even with `inc_ok` held high.
- R5: When parked, a `timer_fire` pulse sets `gen_on` on the next edge only if `readout_en` is high. The first step after a restart leaves column 1 of row 0.
- R6: `le_stb` is high for exactly the one cycle in which a step leaves column 2, in every row.
- R7: `line_stb` is high for exactly the one cycle in which a step leaves column 4, in every row.
- R8: `clr_stb` is high for exactly the one cycle in which a step leaves row 1 column 0, so it fires once per character.
- R9: `blank` is high whenever the row is 0 or the column is 0, 1 or 2, and low otherwise.
- R10: One character takes 64 steps from restart to park, with eight `le_stb`, eight `line_stb` and one `clr_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| readout_en | input | 1 | Readout enabled; gates restarts and steps |
| timer_fire | input | 1 | Restart timer expired pulse |
| inc_ok | input | 1 | Increment permission from dot-brightening logic; low holds |
| row_cnt | output | 3 | Current row of the cell |
| col_cnt | output | 3 | Current column of the cell |
| gen_on | output | 1 | Running flag |
| le_stb | output | 1 | Row load pulse for the pattern generator |
| line_stb | output | 1 | Row advance pulse for the pattern generator |
| clr_stb | output | 1 | Generator row counter clear pulse |
| blank | output | 1 | Position is in the blanked border |

## Verification
A full character scan with the increment input held high shows that positions, wraps and the strobe pattern line up step by step, and that the sequencer parks after 64 steps. A second scan with the increment input dropped at every load column shows that a held position never repeats a strobe. Dropping the readout enable in the middle of a scan shows the difference between enable-gated and increment-gated holds. Timer pulses while parked with the readout off, and idle cycles with the increment input high, show that only an enabled restart leaves the parking spot.

// File: rtl/cscan_pkg.sv
`timescale 1ns/1ps
package cscan_pkg;

    localparam int unsigned CELL_ROWS = 8;
    localparam int unsigned CELL_COLS = 8;
    localparam int unsigned ROW_W     = $clog2(CELL_ROWS);
    localparam int unsigned COL_W     = $clog2(CELL_COLS);
    localparam int unsigned PARK_ROW  = 0;
    localparam int unsigned PARK_COL  = 1;

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [COL_W-1:0] col_t;

    typedef struct packed {
        row_t row;
        col_t col;
    } cell_pos_t;

    typedef struct packed {
        logic load;
        logic line;
        logic clear;
    } strobe_t;

    localparam cell_pos_t PARK_POS   = '{row: row_t'(PARK_ROW), col: col_t'(PARK_COL)};
    localparam cell_pos_t ORIGIN_POS = '{row: '0, col: '0};

    function automatic cell_pos_t pos_next(input cell_pos_t p);
        cell_pos_t n;
        n = p;
        if (p.col == col_t'(CELL_COLS - 1)) begin
            n.col = '0;
            if (p.row == row_t'(CELL_ROWS - 1)) n.row = '0;
            else                                n.row = p.row + 1'b1;
        end else begin
            n.col = p.col + 1'b1;
        end
        return n;
    endfunction

    function automatic logic pos_at(input cell_pos_t p, input int unsigned r, input int unsigned c);
        return (p.row == row_t'(r)) && (p.col == col_t'(c));
    endfunction

endpackage

// File: rtl/cscan_counter.sv
`timescale 1ns/1ps
module cscan_counter
    import cscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    output cell_pos_t pos
);

    cell_pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst)       pos_q <= PARK_POS;
        else if (step) pos_q <= pos_next(pos_q);
    end

    assign pos = pos_q;

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos_q));

    p_col_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step && pos_q.col == col_t'(CELL_COLS - 1)) |=> (pos_q.col == '0));

    p_row_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (step && pos_q.col != col_t'(CELL_COLS - 1)) |=> $stable(pos_q.row));

endmodule

// File: rtl/cscan_gate.sv
`timescale 1ns/1ps
module cscan_gate
    import cscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      readout_en,
    input  logic      timer_fire,
    input  logic      inc_ok,
    input  cell_pos_t pos,
    output logic      running,
    output logic      step
);

    logic run_q;
    logic at_origin;
    logic restart;

    assign at_origin = (pos == ORIGIN_POS);
    assign step      = run_q & readout_en & inc_ok;
    assign restart   = !run_q & timer_fire & readout_en;

    always_ff @(posedge clk) begin
        if (rst)                    run_q <= 1'b0;
        else if (step && at_origin) run_q <= 1'b0;
        else if (restart)           run_q <= 1'b1;
    end

    assign running = run_q;

    p_park_r4: assert property (@(posedge clk) disable iff (rst)
        (step && at_origin) |=> (!run_q && pos == PARK_POS));

    p_start_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !readout_en) |=> !run_q);

    p_idle_still_r4: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(pos));

endmodule

// File: rtl/cscan_decode.sv
`timescale 1ns/1ps
module cscan_decode
    import cscan_pkg::*;
#(
    parameter int unsigned LOAD_COL   = 2,
    parameter int unsigned LINE_COL   = 4,
    parameter int unsigned CLEAR_ROW  = 1,
    parameter int unsigned CLEAR_COL  = 0,
    parameter int unsigned BLANK_COLS = 3,
    parameter int unsigned BLANK_ROWS = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  cell_pos_t pos,
    input  logic      step,
    output strobe_t   stb,
    output logic      blank
);

    localparam col_t LOAD_C  = col_t'(LOAD_COL);
    localparam col_t LINE_C  = col_t'(LINE_COL);
    localparam col_t BLANK_C = col_t'(BLANK_COLS);
    localparam row_t BLANK_R = row_t'(BLANK_ROWS);

    always_comb begin
        stb       = '0;
        stb.load  = step && (pos.col == LOAD_C);
        stb.line  = step && (pos.col == LINE_C);
        stb.clear = step && pos_at(pos, CLEAR_ROW, CLEAR_COL);
    end

    assign blank = (pos.row < BLANK_R) || (pos.col < BLANK_C);

    p_load_next_r6: assert property (@(posedge clk) disable iff (rst)
        stb.load |=> (pos.col == LOAD_C + 1'b1));

    p_line_next_r7: assert property (@(posedge clk) disable iff (rst)
        stb.line |=> (pos.col == LINE_C + 1'b1));

    p_clear_next_r8: assert property (@(posedge clk) disable iff (rst)
        stb.clear |=> (pos.row == row_t'(CLEAR_ROW) && pos.col == col_t'(CLEAR_COL + 1)));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.load, stb.line, stb.clear}));

endmodule

// File: rtl/char_scan_seq.sv
`timescale 1ns/1ps
module char_scan_seq
    import cscan_pkg::*;
#(
    parameter int unsigned LOAD_COL   = 2,
    parameter int unsigned LINE_COL   = 4,
    parameter int unsigned CLEAR_ROW  = 1,
    parameter int unsigned CLEAR_COL  = 0,
    parameter int unsigned BLANK_COLS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             readout_en,
    input  logic             timer_fire,
    input  logic             inc_ok,
    output logic [ROW_W-1:0] row_cnt,
    output logic [COL_W-1:0] col_cnt,
    output logic             gen_on,
    output logic             le_stb,
    output logic             line_stb,
    output logic             clr_stb,
    output logic             blank
);

    cell_pos_t pos;
    strobe_t   stb;
    logic      step;
    logic      running;

    cscan_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .readout_en (readout_en),
        .timer_fire (timer_fire),
        .inc_ok     (inc_ok),
        .pos        (pos),
        .running    (running),
        .step       (step)
    );

    cscan_counter u_count (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .pos  (pos)
    );

    cscan_decode #(
        .LOAD_COL   (LOAD_COL),
        .LINE_COL   (LINE_COL),
        .CLEAR_ROW  (CLEAR_ROW),
        .CLEAR_COL  (CLEAR_COL),
        .BLANK_COLS (BLANK_COLS),
        .BLANK_ROWS (1)
    ) u_dec (
        .clk   (clk),
        .rst   (rst),
        .pos   (pos),
        .step  (step),
        .stb   (stb),
        .blank (blank)
    );

    assign row_cnt  = pos.row;
    assign col_cnt  = pos.col;
    assign gen_on   = running;
    assign le_stb   = stb.load;
    assign line_stb = stb.line;
    assign clr_stb  = stb.clear;

    p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !gen_on |-> !(le_stb || line_stb || clr_stb));

endmodule

// File: tb/char_scan_seq_test.sv
`timescale 1ns/1ps
module char_scan_seq_test;

    logic       clk = 1'b0;
    logic       rst, readout_en, timer_fire, inc_ok;
    logic [2:0] row_cnt, col_cnt;
    logic       gen_on, le_stb, line_stb, clr_stb, blank;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    char_scan_seq uut (
        .clk(clk), .rst(rst), .readout_en(readout_en), .timer_fire(timer_fire),
        .inc_ok(inc_ok), .row_cnt(row_cnt), .col_cnt(col_cnt), .gen_on(gen_on),
        .le_stb(le_stb), .line_stb(line_stb), .clr_stb(clr_stb), .blank(blank)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs change just after a falling edge; outputs are read 0.5 ns later
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; readout_en = 1; timer_fire = 0; inc_ok = 1;
        tick(); tick();
        rst = 0;
        #0.5;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 row", row_cnt, 0);
        check("R1 col", col_cnt, 1);
        check("R1 gen_on", gen_on, 0);
        check("R1 blank", blank, 1);
        check("R1 strobes", {le_stb, line_stb, clr_stb}, 0);
    endtask

    task automatic t_parked();
        do_reset();
        for (int i = 0; i < 5; i++) tick();
        check("R4 parked col with inc high", col_cnt, 1);
        check("R4 parked gen_on", gen_on, 0);
        readout_en = 0; timer_fire = 1;
        tick();
        timer_fire = 0;
        #0.5;
        check("R5 timer ignored without readout", gen_on, 0);
        readout_en = 1;
        tick();
        check("R5 still parked col", col_cnt, 1);
    endtask

    // full scan; hold_le drops inc_ok for two cycles on each load column
    task automatic t_scan(input bit hold_le);
        int er = 0, ec = 1, steps = 0, n_le = 0, n_line = 0, n_clr = 0;
        int pos_err = 0, le_err = 0, line_err = 0, clr_err = 0, blk_err = 0;
        bit held;
        do_reset();
        timer_fire = 1;
        tick();
        timer_fire = 0;
        #0.5;
        check("R5 gen_on after restart", gen_on, 1);
        for (int cyc = 0; cyc < 300 && gen_on; cyc++) begin
            if (row_cnt != er || col_cnt != ec) pos_err++;
            if (blank != ((er == 0) || (ec < 3))) blk_err++;
            held = hold_le && (ec == 2) && inc_ok;
            if (held) begin
                inc_ok = 0;
                #0.5;
                if (le_stb) le_err++;
                tick(); tick();
                if (le_stb) le_err++;
                if (row_cnt != er || col_cnt != ec) pos_err++;
                inc_ok = 1;
                #0.5;
            end
            if (le_stb != (ec == 2)) le_err++;
            if (line_stb != (ec == 4)) line_err++;
            if (clr_stb != (er == 1 && ec == 0)) clr_err++;
            n_le += le_stb; n_line += line_stb; n_clr += clr_stb;
            tick();
            steps++;
            if (ec == 7) begin ec = 0; er = (er + 1) % 8; end
            else ec++;
        end
        check("R3 position track", pos_err, 0);
        check("R9 blank region", blk_err, 0);
        check("R6 load strobe timing", le_err, 0);
        check("R7 line strobe timing", line_err, 0);
        check("R8 clear strobe timing", clr_err, 0);
        check("R10 steps per character", steps, 64);
        check("R10 load pulses", n_le, 8);
        check("R10 line pulses", n_line, 8);
        check("R8 clear pulses", n_clr, 1);
        check("R4 park row", row_cnt, 0);
        check("R4 park col", col_cnt, 1);
        tick(); tick();
        check("R4 stays parked", col_cnt, 1);
    endtask

    task automatic t_enable_hold();
        do_reset();
        timer_fire = 1;
        tick();
        timer_fire = 0;
        tick(); tick(); tick();
        check("R2 col before hold", col_cnt, 4);
        readout_en = 0;
        #0.5;
        check("R2 no line strobe while disabled", line_stb, 0);
        tick(); tick();
        check("R2 col held", col_cnt, 4);
        check("R2 gen_on kept", gen_on, 1);
        readout_en = 1;
        #0.5;
        check("R7 line strobe on resume", line_stb, 1);
        tick();
        check("R2 col resumes", col_cnt, 5);
        check("R9 blank cleared row0 still blank", blank, 1);
    endtask

    initial begin
        rst = 1; readout_en = 0; timer_fire = 0; inc_ok = 0;
        t_reset_state();
        t_parked();
        t_scan(1'b0);
        t_scan(1'b1);
        t_enable_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule